// File: doc/BRIEF.md
# Packet-Command Dispatch Sequencer

This block is the central controller of a board that takes its orders from a host through an Ethernet controller. An eight-valued state register steps the board through a chip-reset phase, an acknowledge transmission, an idle loop that polls the controller's receive-status register, the decoding of a received packet, and one of three service branches: status query, DAC programming, or a return to reset. While in a state that owns a sub-task, the sequencer raises a one-cycle start pulse on that sub-task's line and then waits for its completion pulse. The sub-tasks themselves (chip resets, sensor query, DAC programming and reply transmission) sit outside this block.

All traffic to the Ethernet controller goes through a register bridge with a simple request port. A one-cycle `bus_go` starts a read or a write, and a one-cycle `bus_done` ends it. For a read, `bus_done` comes with the returned byte. The bridge must take at least one cycle after `bus_go` before it pulses `bus_done`. The sequencer has at most one request in flight. The receive-status register, the receive-data register, the skip register and the skip command value are parameters.

When the host sends a reset command, its second payload byte becomes the chip-select mask for the next reset phase. The mask is presented on `rst_mask` and held there until another reset command replaces it.

Top module: `pkt_dispatch_seq`

## Requirements
- R1: While reset is low and after it is released, `state` is 0, `rst_mask` is all ones and `bus_go` is low. In the first cycle after release, `task_go` is 8'h01.
- R2: State 0 moves to state 1 on `task_done[0]`, and state 1 moves to state 2 on `task_done[1]`. Each move is visible the cycle after the done pulse.
- R3: On entry to each sub-task state (codes 0, 1, 4, 5, 6, 7), `task_go` pulses for exactly one cycle, with only the bit indexed by the state code set. `task_go` is never raised in states 2 or 3.
- R4: In state 2, the block issues reads of register 0x76. If bit 6 of the returned byte is 1, it stays in state 2 and reads again. If bit 6 is 0, it moves to state 3.
- R5: In state 3, the block reads the command byte from the receive-data register (0x11). Command 0x52 ('R') ends in state 0, 0x51 ('Q') in state 4, 0x50 ('P') in state 6, and any other value in state 2.
- R6: For command 0x52, a second read of the receive-data register follows. The low 4 bits of that byte are loaded into `rst_mask`. No other path changes `rst_mask`.
- R7: For 'R', 'Q' and invalid commands, the block writes the skip value 0x02 to register 0x12 and stays in state 3 until that write's `bus_done` arrives. A 'P' command moves to state 6 with no write.
- R8: In state 6, `task_done[6]` triggers the skip write. Only after that write's `bus_done` does the block move to state 7.
- R9: State 4 moves to state 5 on its done pulse, and states 5 and 7 move to state 2 on theirs.
- R10: `bus_go` is a one-cycle pulse, and no new request starts while one is outstanding. `bus_go` is low in the cycle a new state appears.
- R11: A `bus_done` pulse with no request outstanding, or a `task_done` bit that does not belong to the current state, changes neither the state nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_go | output | 1 | One-cycle request strobe to the register bridge |
| bus_rd | output | 1 | Request direction: 1 read, 0 write |
| bus_addr | output | 8 | Register address of the request |
| bus_wdata | output | 8 | Write data of the request |
| bus_done | input | 1 | One-cycle completion strobe from the bridge |
| bus_rdata | input | 8 | Read data, valid with `bus_done` |
| task_go | output | 8 | Sub-task start pulses, indexed by state code |
| task_done | input | 8 | Sub-task completion pulses, indexed by state code |
| rst_mask | output | 4 | Chip-reset selection mask for the reset phase |
| state | output | 3 | Current sequencer state code |

## Verification
The bench runs random command bytes and random bridge and sub-task latencies, plus directed 'R', 'Q', 'P' and near-miss bytes such as lower-case 'r' and 0xFF.

It varies the number of polls that report an empty receive FIFO. A design that tested the wrong status bit would leave idle too early or never leave it.

It checks that the state holds in state 3 while the skip write is outstanding. A design that moved on at issue rather than at completion would show the new state too soon. It also checks that a 'P' packet produces no skip write until the DAC task is done.

Stray `bus_done` pulses and foreign `task_done` bits are injected while a sub-task runs. A design that did not qualify its done inputs would advance early.

// File: rtl/pds_pkg.sv
// Shared types and constants of the packet-command dispatch sequencer.
// Assumes: state codes are fixed because sub-task enables decode them.
package pds_pkg;

    localparam int ST_W = 3;
    localparam int N_ST = 8;

    typedef enum logic [ST_W-1:0] {
        ST_RESET   = 3'd0,
        ST_ACK     = 3'd1,
        ST_IDLE    = 3'd2,
        ST_READ    = 3'd3,
        ST_QUERY   = 3'd4,
        ST_SREPLY  = 3'd5,
        ST_DACPROG = 3'd6,
        ST_DREPLY  = 3'd7
    } seq_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_POLL,
        OP_CMD,
        OP_ARG,
        OP_SKIP
    } bus_op_e;

    typedef enum logic [1:0] {
        CMD_RESET,
        CMD_QUERY,
        CMD_PROG,
        CMD_BAD
    } cmd_kind_e;

    // States that own an external sub-task (bit index = state code)
    localparam logic [N_ST-1:0] TASK_STATES = 8'b1111_0011;

    localparam logic [7:0] CHAR_RESET = 8'h52;
    localparam logic [7:0] CHAR_QUERY = 8'h51;
    localparam logic [7:0] CHAR_PROG  = 8'h50;

    // Fixed successor of a plain sub-task state once its task completes
    function automatic seq_state_e task_successor(input seq_state_e s);
        case (s)
            ST_RESET:  return ST_ACK;
            ST_QUERY:  return ST_SREPLY;
            default:   return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/pds_cmd_decode.sv
// Classifies a received command byte into one of the branch kinds.
// Assumes: DATA_W >= 8; the command characters occupy the low byte.
module pds_cmd_decode
    import pds_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] cmd_byte,
    output cmd_kind_e         cmd_kind
);

    // Compare the byte against each known command character
    always_comb begin
        if (cmd_byte == DATA_W'(CHAR_RESET))
            cmd_kind = CMD_RESET;
        else if (cmd_byte == DATA_W'(CHAR_QUERY))
            cmd_kind = CMD_QUERY;
        else if (cmd_byte == DATA_W'(CHAR_PROG))
            cmd_kind = CMD_PROG;
        else
            cmd_kind = CMD_BAD;
    end

endmodule

// File: rtl/pds_bus_req.sv
// Registers one bridge request per issue strobe and maps the operation
// kind to direction, address and write data.
// Assumes: issue is never asserted in two consecutive cycles, and the
// bridge answers no earlier than one cycle after the go strobe.
module pds_bus_req
    import pds_pkg::*;
#(
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 8,
    parameter logic [ADDR_W-1:0]  POLL_ADDR = 'h76,
    parameter logic [ADDR_W-1:0]  RXD_ADDR  = 'h11,
    parameter logic [ADDR_W-1:0]  SKIP_ADDR = 'h12,
    parameter logic [DATA_W-1:0]  SKIP_VAL  = 'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  bus_op_e           issue_op,
    output logic              go,
    output logic              rd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);

    // Launch the request fields and the one-cycle go strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go    <= 1'b0;
            rd    <= 1'b0;
            addr  <= '0;
            wdata <= '0;
        end else begin
            go <= issue;
            if (issue) begin
                case (issue_op)
                    OP_POLL: begin
                        rd    <= 1'b1;
                        addr  <= POLL_ADDR;
                        wdata <= '0;
                    end
                    OP_CMD, OP_ARG: begin
                        rd    <= 1'b1;
                        addr  <= RXD_ADDR;
                        wdata <= '0;
                    end
                    OP_SKIP: begin
                        rd    <= 1'b0;
                        addr  <= SKIP_ADDR;
                        wdata <= SKIP_VAL;
                    end
                    default: begin
                        rd    <= rd;
                        addr  <= addr;
                        wdata <= wdata;
                    end
                endcase
            end
        end
    end

    AST_GO_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);  // R10

endmodule

// File: rtl/pds_entry.sv
// Tracks the first cycle of each state and turns it into the start pulse
// of the sub-task owned by that state.
// Assumes: advance is high only in the cycle the state register is written.
module pds_entry
    import pds_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic [ST_W-1:0] cur_state,
    output logic            fresh,
    output logic [N_ST-1:0] task_go
);

    // Mark the cycle following reset or a state write as an entry cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            fresh <= 1'b1;
        else
            fresh <= advance;
    end

    for (genvar i = 0; i < N_ST; i++) begin : g_go
        if (TASK_STATES[i]) begin : g_owner
            assign task_go[i] = fresh & rst_n & (cur_state == ST_W'(i));
        end else begin : g_none
            assign task_go[i] = 1'b0;
        end
    end

    AST_TASK_GO_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(task_go));  // R3
    AST_TASK_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (task_go != '0) |=> (task_go == '0));  // R3

endmodule

// File: rtl/pkt_dispatch_seq.sv
// Packet-command dispatch sequencer: owns the state register, polls the
// receive status, decodes commands, latches the reset mask and decides
// when a packet is skipped.
// Assumes: one bridge request at a time, bridge done no earlier than one
// cycle after go, and sub-task done pulses arrive after their start pulse.
module pkt_dispatch_seq
    import pds_pkg::*;
#(
    parameter int                 ADDR_W    = 8,
    parameter int                 DATA_W    = 8,
    parameter int                 MASK_W    = 4,
    parameter int                 POLL_BIT  = 6,
    parameter logic [ADDR_W-1:0]  POLL_ADDR = 'h76,
    parameter logic [ADDR_W-1:0]  RXD_ADDR  = 'h11,
    parameter logic [ADDR_W-1:0]  SKIP_ADDR = 'h12,
    parameter logic [DATA_W-1:0]  SKIP_VAL  = 'h02
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              bus_go,
    output logic              bus_rd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [N_ST-1:0]   task_go,
    input  logic [N_ST-1:0]   task_done,
    output logic [MASK_W-1:0] rst_mask,
    output logic [ST_W-1:0]   state
);

    seq_state_e        state_q, state_d;
    seq_state_e        dest_q, dest_d;
    bus_op_e           op_q, op_d, iop;
    logic [MASK_W-1:0] mask_q, mask_d;
    logic              advance, issue, fresh;
    logic              bus_ack, task_ack;
    cmd_kind_e         kind;

    pds_cmd_decode #(.DATA_W(DATA_W)) u_decode (
        .cmd_byte (bus_rdata),
        .cmd_kind (kind)
    );

    pds_entry u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .cur_state (state_q),
        .fresh     (fresh),
        .task_go   (task_go)
    );

    pds_bus_req #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .POLL_ADDR (POLL_ADDR),
        .RXD_ADDR  (RXD_ADDR),
        .SKIP_ADDR (SKIP_ADDR),
        .SKIP_VAL  (SKIP_VAL)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (issue),
        .issue_op (iop),
        .go       (bus_go),
        .rd       (bus_rd),
        .addr     (bus_addr),
        .wdata    (bus_wdata)
    );

    // Qualify done strobes: bus done only with a request pending, task done
    // only for the current state's own bit and after its start cycle
    assign bus_ack  = bus_done && (op_q != OP_NONE);
    assign task_ack = task_done[state_q] && !fresh && TASK_STATES[state_q];

    // Next-state, request and mask decision for the current state
    always_comb begin
        state_d = state_q;
        dest_d  = dest_q;
        mask_d  = mask_q;
        op_d    = op_q;
        advance = 1'b0;
        issue   = 1'b0;
        iop     = OP_NONE;
        if (bus_ack)
            op_d = OP_NONE;
        case (state_q)
            ST_IDLE: begin
                if (fresh) begin
                    issue = 1'b1;
                    iop   = OP_POLL;
                end else if (bus_ack && op_q == OP_POLL) begin
                    if (bus_rdata[POLL_BIT]) begin
                        issue = 1'b1;
                        iop   = OP_POLL;
                    end else begin
                        advance = 1'b1;
                        state_d = ST_READ;
                    end
                end
            end
            ST_READ: begin
                if (fresh) begin
                    issue = 1'b1;
                    iop   = OP_CMD;
                end else if (bus_ack) begin
                    case (op_q)
                        OP_CMD: begin
                            case (kind)
                                CMD_RESET: begin
                                    issue = 1'b1;
                                    iop   = OP_ARG;
                                end
                                CMD_QUERY: begin
                                    issue  = 1'b1;
                                    iop    = OP_SKIP;
                                    dest_d = ST_QUERY;
                                end
                                CMD_PROG: begin
                                    advance = 1'b1;
                                    state_d = ST_DACPROG;
                                end
                                default: begin
                                    issue  = 1'b1;
                                    iop    = OP_SKIP;
                                    dest_d = ST_IDLE;
                                end
                            endcase
                        end
                        OP_ARG: begin
                            mask_d = bus_rdata[MASK_W-1:0];
                            issue  = 1'b1;
                            iop    = OP_SKIP;
                            dest_d = ST_RESET;
                        end
                        OP_SKIP: begin
                            advance = 1'b1;
                            state_d = dest_q;
                        end
                        default: ;
                    endcase
                end
            end
            ST_DACPROG: begin
                if (task_ack && op_q == OP_NONE) begin
                    issue  = 1'b1;
                    iop    = OP_SKIP;
                    dest_d = ST_DREPLY;
                end else if (bus_ack && op_q == OP_SKIP) begin
                    advance = 1'b1;
                    state_d = dest_q;
                end
            end
            default: begin
                if (task_ack) begin
                    advance = 1'b1;
                    state_d = task_successor(state_q);
                end
            end
        endcase
        if (issue)
            op_d = iop;
    end

    // Hold state, pending operation, branch target and reset mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            dest_q  <= ST_IDLE;
            op_q    <= OP_NONE;
            mask_q  <= '1;
        end else begin
            state_q <= state_d;
            dest_q  <= dest_d;
            op_q    <= op_d;
            mask_q  <= mask_d;
        end
    end

    assign state    = state_q;
    assign rst_mask = mask_q;

    AST_QUIET_BUS_ON_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> !bus_go);  // R10
    AST_ONE_REQ_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !bus_ack) |-> (op_q == OP_NONE));  // R10
    AST_POLL_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_q == OP_POLL && bus_done && !bus_rdata[POLL_BIT])
        |=> (state_q == ST_READ));  // R4
    AST_POLL_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_q == OP_POLL && bus_done && bus_rdata[POLL_BIT])
        |=> (state_q == ST_IDLE && bus_go));  // R4
    AST_RESET_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET && task_done[0] && !fresh) |=> (state_q == ST_ACK));  // R2
    AST_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READ) |-> $stable(mask_q));  // R6
    AST_SKIP_BEFORE_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_READ && state_q != ST_READ && state_q != ST_DACPROG)
        |-> ($past(op_q) == OP_SKIP));  // R7
    AST_MOVE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> ($past(bus_done) || $past(task_done) != '0));  // R11

endmodule

// File: tb/pkt_dispatch_seq_tb.sv
`timescale 1ns/1ps
module pkt_dispatch_seq_tb;

    localparam logic [7:0] POLL_A = 8'h76;
    localparam logic [7:0] RXD_A  = 8'h11;
    localparam logic [7:0] SKIP_A = 8'h12;
    localparam logic [7:0] SKIP_V = 8'h02;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_go, bus_rd;
    logic [7:0] bus_addr, bus_wdata;
    logic       bus_done = 1'b0;
    logic [7:0] bus_rdata = 8'h00;
    logic [7:0] task_go;
    logic [7:0] task_done = 8'h00;
    logic [3:0] rst_mask;
    logic [2:0] state;

    int nchk = 0;
    int nfail = 0;
    logic [3:0] exp_mask = 4'hF;

    always #2 clk = ~clk;

    pkt_dispatch_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_go    (bus_go),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_done  (bus_done),
        .bus_rdata (bus_rdata),
        .task_go   (task_go),
        .task_done (task_done),
        .rst_mask  (rst_mask),
        .state     (state)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected state reached after a command byte is fully handled in state 3
    function automatic int exp_after_cmd(input logic [7:0] c);
        case (c)
            8'h52:   return 0;
            8'h51:   return 4;
            8'h50:   return 6;
            default: return 2;
        endcase
    endfunction

    // Wait for one request, check its fields, answer after a random delay
    task automatic serve_bus(input bit erd, input logic [7:0] eaddr,
                             input logic [7:0] ewd, input logic [7:0] resp,
                             input string tag);
        while (!bus_go) @(negedge clk);
        chk(bus_rd == erd, tag, bus_rd, erd);
        chk(bus_addr == eaddr, tag, bus_addr, eaddr);
        if (!erd) chk(bus_wdata == ewd, tag, bus_wdata, ewd);
        @(negedge clk);
        chk(!bus_go, "R10 go single cycle", bus_go, 0);
        repeat ($urandom_range(0, 3)) begin
            @(negedge clk);
            chk(!bus_go, "R10 no second request", bus_go, 0);
        end
        bus_done  = 1'b1;
        bus_rdata = resp;
        @(negedge clk);
        bus_done  = 1'b0;
        bus_rdata = 8'($urandom);
    endtask

    // Wait for a start pulse, check it, optionally inject stray dones, finish
    task automatic serve_task(input int idx, input bit stray, input string tag);
        while (task_go == 8'h00) @(negedge clk);
        chk(task_go == 8'(1 << idx), tag, task_go, 1 << idx);
        @(negedge clk);
        chk(task_go == 8'h00, "R3 start pulse one cycle", task_go, 0);
        if (stray) begin
            bus_done  = 1'b1;
            bus_rdata = 8'h00;
            task_done = 8'h2C & ~8'(1 << idx);
            @(negedge clk);
            bus_done  = 1'b0;
            task_done = 8'h00;
            @(negedge clk);
            chk(state == 3'(idx), "R11 stray done ignored", state, idx);
            chk(!bus_go && task_go == 8'h00, "R11 no output on stray", {bus_go, task_go}, 0);
        end
        repeat ($urandom_range(0, 3)) @(negedge clk);
        task_done[idx] = 1'b1;
        @(negedge clk);
        task_done = 8'h00;
    endtask

    task automatic run_packet(input logic [7:0] c, input logic [7:0] arg);
        int npoll = $urandom_range(0, 3);
        for (int i = 0; i < npoll; i++) begin
            serve_bus(1'b1, POLL_A, 8'h00, 8'($urandom) | 8'h40, "R4 poll read");
            chk(state == 3'd2, "R4 stay idle while empty", state, 2);
        end
        serve_bus(1'b1, POLL_A, 8'h00, 8'($urandom) & 8'hBF, "R4 poll read");
        chk(state == 3'd3, "R4 leave idle", state, 3);
        serve_bus(1'b1, RXD_A, 8'h00, c, "R5 command read");
        case (exp_after_cmd(c))
            0: begin
                chk(state == 3'd3, "R6 stay for argument", state, 3);
                serve_bus(1'b1, RXD_A, 8'h00, arg, "R6 argument read");
                chk(state == 3'd3, "R7 hold until skip done", state, 3);
                serve_bus(1'b0, SKIP_A, SKIP_V, 8'($urandom), "R7 skip write");
                exp_mask = arg[3:0];
                chk(state == 3'd0, "R5 R goes to reset", state, 0);
                chk(rst_mask == exp_mask, "R6 mask latched", rst_mask, exp_mask);
                serve_task(0, 1'b0, "R3 reset start");
                chk(state == 3'd1, "R2 reset to ack", state, 1);
                serve_task(1, 1'b0, "R3 ack start");
                chk(state == 3'd2, "R2 ack to idle", state, 2);
            end
            4: begin
                chk(state == 3'd3, "R7 hold until skip done", state, 3);
                serve_bus(1'b0, SKIP_A, SKIP_V, 8'($urandom), "R7 skip write");
                chk(state == 3'd4, "R5 Q goes to query", state, 4);
                serve_task(4, 1'b1, "R3 query start");
                chk(state == 3'd5, "R9 query to status reply", state, 5);
                serve_task(5, 1'b0, "R3 status reply start");
                chk(state == 3'd2, "R9 status reply to idle", state, 2);
            end
            6: begin
                chk(state == 3'd6, "R7 P kept, no skip", state, 6);
                chk(!bus_go, "R7 P no bus write", bus_go, 0);
                serve_task(6, 1'b0, "R3 dac start");
                serve_bus(1'b0, SKIP_A, SKIP_V, 8'($urandom), "R8 dac skip write");
                chk(state == 3'd7, "R8 dac to dac reply", state, 7);
                serve_task(7, 1'b0, "R3 dac reply start");
                chk(state == 3'd2, "R9 dac reply to idle", state, 2);
            end
            default: begin
                chk(state == 3'd3, "R7 hold until skip done", state, 3);
                serve_bus(1'b0, SKIP_A, SKIP_V, 8'($urandom), "R7 skip write");
                chk(state == 3'd2, "R5 invalid back to idle", state, 2);
            end
        endcase
        chk(rst_mask == exp_mask, "R6 mask held", rst_mask, exp_mask);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        chk(state == 3'd0, "R1 reset state", state, 0);
        chk(rst_mask == 4'hF, "R1 reset mask", rst_mask, 4'hF);
        chk(!bus_go, "R1 bus idle in reset", bus_go, 0);
        rst_n = 1'b1;
        #1;
        chk(task_go == 8'h01, "R1 first reset start", task_go, 1);
        serve_task(0, 1'b0, "R3 reset start");
        chk(state == 3'd1, "R2 reset to ack", state, 1);
        serve_task(1, 1'b0, "R3 ack start");
        chk(state == 3'd2, "R2 ack to idle", state, 2);
        run_packet(8'h52, 8'hA5);
        run_packet(8'h51, 8'h00);
        run_packet(8'h50, 8'h00);
        run_packet(8'h72, 8'h00);
        run_packet(8'hFF, 8'h00);
        run_packet(8'h00, 8'h00);
        run_packet(8'h52, 8'h3C);
        for (int k = 0; k < 40; k++) begin
            logic [7:0] c;
            case ($urandom_range(0, 4))
                0: c = 8'h52;
                1: c = 8'h51;
                2: c = 8'h50;
                default: c = 8'($urandom);
            endcase
            run_packet(c, 8'($urandom));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule